// File: doc/BRIEF.md
# Multi-CPU host bus adapter

This block is a synchronous slave that sits between a host processor bus and one internal request/acknowledge access port. It accepts chip select, a one-cycle bus-start pulse, a read strobe, four byte-lane write strobes, a 32-bit data path and a 23-bit word address, which spans 32 MB. It turns each host cycle into one internal request, holds the host in wait until the internal side acknowledges, then signals ready.

Three host bus styles are supported, called type A, type B and type C. A two-bit type code is sampled while reset is held and is kept for the rest of the session. That code sets the level that means ready on the handshake output. It also sets the active level of the DMA transfer strobe input and of the interrupt output. The handshake output is driven only while the host selects the block.

The block also runs a DMA request handshake for an external DMA controller. The internal side loads a word count. The request stays active until that many acknowledged strobes have been seen. A one-bit internal interrupt source is registered and presented to the host at the level that means active for the selected type. Tristate data and ready pins are expressed as value and output-enable pairs, ready for a pad ring.

Top module: `hostbus_adapter`

## Requirements
- R1: The type code `cpu_sel` is captured on every clock edge while `rst_n` is low. Changes to it after release have no effect. Code 00 is type A, 01 is type B, 10 is type C. Code 11 behaves as type A and sets `mode_bad` to 1. `mode_bad` is 0 for every other code.
- R2: `rdy_oe` is 1 exactly while `bus_cs_n` is 0. When `bus_cs_n` is 1 the ready pin is released.
- R3: In type A, `rdy_o` = 1 means ready and 0 means wait. In types B and C, `rdy_o` = 0 means ready and 1 means wait.
- R4: An access starts in the cycle after an edge that samples `bus_cs_n`=0 and `bus_start_n`=0 while the block is idle. `int_req` then stays high until an edge samples `int_ack`=1. Ready is then shown for exactly one clock, and the block returns to idle. Ready is shown in the next cycle for a write, and in the second cycle after that for a read.
- R5: During a write, the internal port carries the address, data and strobes that were sampled at the start edge. `int_we` is 1, and `int_be[i]` = 1 when `bus_we_n[i]` was 0. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R6: A cycle with `bus_rd_n`=1 and all four `bus_we_n` bits at 1 is a no-operation. It raises no `int_req`, and ready is shown in the cycle after the start edge.
- R7: On a read, `bus_dq_oe` rises in the cycle after the acknowledging edge, which is one clock before the ready cycle. `bus_dq_o` then carries the acknowledged `int_rdata`. Both stay as they are while `bus_rd_n` stays 0. `bus_dq_oe` drops at once when `bus_rd_n` returns to 1 after the ready cycle.
- R8: `dma_req_n` is active low. It goes to 0 in the cycle after an edge with `dma_go`=1 loads a nonzero `dma_words`. It returns to 1 in the cycle after the edge that counts the last of those words.
- R9: A word is counted on a clock edge only when `dma_ack` is 1, which is active high in every type, and `dma_stb` is at its active level. That level is 1 for types A and B and 0 for type C.
- R10: `irq_o` follows `irq_src` one clock later. It is active low in types A and B and active high in type C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_sel | input | 2 | Host type code, sampled during reset |
| mode_bad | output | 1 | Reserved type code was captured |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_start_n | input | 1 | Bus cycle start, active low, one clock |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_we_n | input | 4 | Byte-lane write strobes, active low |
| bus_addr | input | 23 | Word address |
| bus_dq_i | input | 32 | Write data from host |
| bus_dq_o | output | 32 | Read data to host |
| bus_dq_oe | output | 1 | Data pin drive enable |
| rdy_o | output | 1 | Ready/wait level |
| rdy_oe | output | 1 | Ready pin drive enable |
| dma_req_n | output | 1 | DMA request, active low |
| dma_ack | input | 1 | DMA acknowledge, active high |
| dma_stb | input | 1 | DMA transfer strobe, polarity per type |
| dma_go | input | 1 | Internal: load transfer count |
| dma_words | input | 12 | Internal: words in the transfer |
| irq_src | input | 1 | Internal interrupt source, active high |
| irq_o | output | 1 | Host interrupt, polarity per type |
| int_req | output | 1 | Internal access request |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | 23 | Internal word address |
| int_be | output | 4 | Internal byte enables |
| int_wdata | output | 32 | Internal write data |
| int_ack | input | 1 | Internal access acknowledge |
| int_rdata | input | 32 | Internal read data |

## Verification
The properties take a well-behaved host for granted. The host pulses `bus_start_n` for a single clock only when the block is idle. It keeps chip select, read strobe and write strobes steady from the start edge until it has seen ready, and it raises `int_ack` only while `int_req` is high. The stimulus stays within these limits because every access runs through one bench task. That task walks the handshake step by step and only randomises the address, data, byte strobes, read or write choice, and the number of wait cycles. DMA strobes and `dma_go` are never issued while an access's internal acknowledge is pending, and the count is only reloaded once the previous transfer has finished.

// File: rtl/hostbus_adapter.sv
module hostbus_adapter #(
  parameter int AW = 23,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpu_sel,
  output logic          mode_bad,
  input  logic          bus_cs_n,
  input  logic          bus_start_n,
  input  logic          bus_rd_n,
  input  logic [DW/8-1:0] bus_we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_dq_i,
  output logic [DW-1:0] bus_dq_o,
  output logic          bus_dq_oe,
  output logic          rdy_o,
  output logic          rdy_oe,
  output logic          dma_req_n,
  input  logic          dma_ack,
  input  logic          dma_stb,
  input  logic          dma_go,
  input  logic [CW-1:0] dma_words,
  input  logic          irq_src,
  output logic          irq_o,
  output logic          int_req,
  output logic          int_we,
  output logic [AW-1:0] int_addr,
  output logic [DW/8-1:0] int_be,
  output logic [DW-1:0] int_wdata,
  input  logic          int_ack,
  input  logic [DW-1:0] int_rdata
);
  localparam int BW = DW / 8;

  typedef enum logic [2:0] {S_IDLE, S_BUSY, S_DRV, S_RDY, S_HOLD} st_t;

  st_t           st;
  logic [1:0]    mode_q;
  logic          rd_q;
  logic [DW-1:0] rdata_q;
  logic [CW-1:0] remain;
  logic          irq_q;

  wire type_c  = (mode_q == 2'b10);
  wire type_b  = (mode_q == 2'b01);
  wire type_a  = !type_c && !type_b;
  wire noop    = bus_rd_n && (&bus_we_n);
  wire stb_on  = type_c ? !dma_stb : dma_stb;
  wire is_rdy  = (st == S_RDY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= cpu_sel;
      st        <= S_IDLE;
      rd_q      <= 1'b0;
      rdata_q   <= '0;
      int_addr  <= '0;
      int_be    <= '0;
      int_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (!bus_cs_n && !bus_start_n) begin
          int_addr  <= bus_addr;
          int_wdata <= bus_dq_i;
          int_be    <= bus_rd_n ? ~bus_we_n : {BW{1'b1}};
          rd_q      <= !bus_rd_n;
          st        <= noop ? S_RDY : S_BUSY;
        end
        S_BUSY: if (int_ack) begin
          rdata_q <= int_rdata;
          st      <= rd_q ? S_DRV : S_RDY;
        end
        S_DRV:   st <= S_RDY;
        S_RDY:   st <= (rd_q && !bus_rd_n) ? S_HOLD : S_IDLE;
        S_HOLD:  if (bus_rd_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_src;
      if (dma_go)
        remain <= dma_words;
      else if (dma_ack && stb_on && remain != '0)
        remain <= remain - 1'b1;
    end
  end

  assign mode_bad  = (mode_q == 2'b11);
  assign int_req   = (st == S_BUSY);
  assign int_we    = !rd_q;
  assign rdy_oe    = !bus_cs_n;
  assign rdy_o     = type_a ? is_rdy : !is_rdy;
  assign bus_dq_o  = rdata_q;
  assign bus_dq_oe = rd_q && ((st == S_DRV) || is_rdy || (st == S_HOLD && !bus_rd_n));
  assign dma_req_n = (remain == '0);
  assign irq_o     = type_c ? irq_q : !irq_q;
endmodule

// File: rtl/hostbus_adapter_chk.sv
module hostbus_adapter_chk #(
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_q,
  input logic          bus_cs_n,
  input logic          rdy_o,
  input logic          rdy_oe,
  input logic          int_req,
  input logic          int_ack,
  input logic [BW-1:0] int_be,
  input logic          bus_dq_oe,
  input logic          dma_req_n,
  input logic          dma_ack
);
  wire low_ready = (mode_q == 2'b01) || (mode_q == 2'b10);
  wire ready_now = rdy_oe && (rdy_o == !low_ready);

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  assert_rdy_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> !rdy_oe);

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_now |=> !ready_now);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> int_req);

  assert_noop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int_be != '0));

  assert_dq_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dq_oe |-> !int_req);

  assert_dreq_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dma_req_n) && $past(rst_n)) |-> $past(dma_ack));
endmodule

bind hostbus_adapter hostbus_adapter_chk #(.BW(DW/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .bus_cs_n(bus_cs_n),
  .rdy_o(rdy_o), .rdy_oe(rdy_oe), .int_req(int_req), .int_ack(int_ack),
  .int_be(int_be), .bus_dq_oe(bus_dq_oe), .dma_req_n(dma_req_n), .dma_ack(dma_ack)
);

// File: tb/hostbus_adapter_bench.sv
module hostbus_adapter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cpu_sel = 2'b00;
  logic        mode_bad;
  logic        bus_cs_n = 1'b1, bus_start_n = 1'b1, bus_rd_n = 1'b1;
  logic [3:0]  bus_we_n = 4'hf;
  logic [22:0] bus_addr = '0;
  logic [31:0] bus_dq_i = '0, bus_dq_o;
  logic        bus_dq_oe, rdy_o, rdy_oe, dma_req_n;
  logic        dma_ack = 1'b0, dma_stb = 1'b0, dma_go = 1'b0;
  logic [11:0] dma_words = '0;
  logic        irq_src = 1'b0, irq_o;
  logic        int_req, int_we;
  logic [22:0] int_addr;
  logic [3:0]  int_be;
  logic [31:0] int_wdata;
  logic        int_ack = 1'b0;
  logic [31:0] int_rdata = '0;

  int checks = 0, errors = 0;
  logic [1:0] cur = 2'b00;

  always #5 clk = ~clk;

  hostbus_adapter u_hostbus_adapter (
    .clk, .rst_n, .cpu_sel, .mode_bad, .bus_cs_n, .bus_start_n, .bus_rd_n,
    .bus_we_n, .bus_addr, .bus_dq_i, .bus_dq_o, .bus_dq_oe, .rdy_o, .rdy_oe,
    .dma_req_n, .dma_ack, .dma_stb, .dma_go, .dma_words, .irq_src, .irq_o,
    .int_req, .int_we, .int_addr, .int_be, .int_wdata, .int_ack, .int_rdata
  );

  function automatic logic lvl_ready(logic [1:0] m, logic rdy);
    return (m == 2'b01 || m == 2'b10) ? !rdy : rdy;
  endfunction
  function automatic logic lvl_irq(logic [1:0] m, logic act);
    return (m == 2'b10) ? act : !act;
  endfunction
  function automatic logic lvl_stb(logic [1:0] m, logic act);
    return (m == 2'b10) ? !act : act;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", tag, cur, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    cur = m;
    rst_n = 1'b0;
    cpu_sel = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cpu_sel = ~m;
    @(negedge clk);
    chk("R1 mode_bad", {31'd0, mode_bad}, {31'd0, m == 2'b11});
    chk("R2 rdy released", {31'd0, rdy_oe}, 32'd0);
    chk("R4 idle req", {31'd0, int_req}, 32'd0);
    chk("R8 dreq idle", {31'd0, dma_req_n}, 32'd1);
    chk("R10 irq idle", {31'd0, irq_o}, {31'd0, lvl_irq(m, 1'b0)});
  endtask

  task automatic access(logic rd, logic [3:0] wen, logic [22:0] a, logic [31:0] d, int waits);
    logic [31:0] rv;
    logic noop;
    noop = !rd && (wen == 4'hf);
    bus_cs_n = 1'b0; bus_start_n = 1'b0; bus_rd_n = !rd;
    bus_we_n = rd ? 4'hf : wen; bus_addr = a; bus_dq_i = d;
    @(negedge clk);
    bus_start_n = 1'b1;
    bus_dq_i = ~d;
    if (noop) begin
      chk("R6 noop ready", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b1)});
      chk("R6 noop no req", {31'd0, int_req}, 32'd0);
      @(negedge clk);
      chk("R4 back to wait", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b0)});
    end else begin
      for (int w = 0; w < waits; w++) begin
        chk("R4 req held", {31'd0, int_req}, 32'd1);
        chk("R3 wait level", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b0)});
        @(negedge clk);
      end
      chk("R4 req", {31'd0, int_req}, 32'd1);
      chk("R5 addr", {9'd0, int_addr}, {9'd0, a});
      chk("R5 we", {31'd0, int_we}, {31'd0, !rd});
      if (!rd) begin
        chk("R5 be", {28'd0, int_be}, {28'd0, ~wen});
        chk("R5 wdata", int_wdata, d);
      end
      rv = $urandom;
      int_ack = 1'b1; int_rdata = rv;
      @(negedge clk);
      int_ack = 1'b0; int_rdata = ~rv;
      if (rd) begin
        chk("R7 early drive", {31'd0, bus_dq_oe}, 32'd1);
        chk("R7 early data", bus_dq_o, rv);
        chk("R3 wait before ready", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b0)});
        @(negedge clk);
        chk("R4 read ready", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b1)});
        chk("R7 data at ready", bus_dq_o, rv);
        @(negedge clk);
        chk("R7 hold drive", {31'd0, bus_dq_oe}, 32'd1);
        chk("R4 single ready", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b0)});
      end else begin
        chk("R4 write ready", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b1)});
        chk("R4 req dropped", {31'd0, int_req}, 32'd0);
        @(negedge clk);
        chk("R4 single ready", {31'd0, rdy_o}, {31'd0, lvl_ready(cur, 1'b0)});
      end
    end
    bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_we_n = 4'hf;
    #1;
    chk("R2 rdy release", {31'd0, rdy_oe}, 32'd0);
    chk("R7 data release", {31'd0, bus_dq_oe}, 32'd0);
    @(negedge clk);
  endtask

  task automatic dma_test(logic [11:0] n);
    dma_go = 1'b1; dma_words = n;
    @(negedge clk);
    dma_go = 1'b0;
    chk("R8 dreq on", {31'd0, dma_req_n}, 32'd0);
    dma_ack = 1'b1; dma_stb = lvl_stb(cur, 1'b0);
    @(negedge clk);
    dma_ack = 1'b0; dma_stb = lvl_stb(cur, 1'b1);
    @(negedge clk);
    for (int i = 1; i <= n; i++) begin
      dma_ack = 1'b1; dma_stb = lvl_stb(cur, 1'b1);
      @(negedge clk);
      if (i < n) chk("R9 count only qualified", {31'd0, dma_req_n}, 32'd0);
    end
    dma_ack = 1'b0; dma_stb = lvl_stb(cur, 1'b0);
    chk("R8 dreq off", {31'd0, dma_req_n}, 32'd1);
    @(negedge clk);
  endtask

  task automatic irq_test();
    irq_src = 1'b1;
    @(negedge clk);
    chk("R10 irq active", {31'd0, irq_o}, {31'd0, lvl_irq(cur, 1'b1)});
    irq_src = 1'b0;
    @(negedge clk);
    chk("R10 irq inactive", {31'd0, irq_o}, {31'd0, lvl_irq(cur, 1'b0)});
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      access(1'b0, 4'b0000, 23'h7fffff, 32'hdeadbeef, 0);
      access(1'b1, 4'hf, 23'h000000, 32'h0, 2);
      access(1'b0, 4'hf, 23'h001234, 32'h12345678, 0);
      access(1'b0, 4'b1110, 23'h000010, 32'h000000a5, 3);
      for (int i = 0; i < 10; i++)
        access(1'($urandom), 4'($urandom), 23'($urandom), $urandom, int'($urandom % 4));
      dma_test(12'd3);
      dma_test(12'd1);
      irq_test();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule